// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Bridge

This bridge connects a processor core's data path to an external static RAM over a narrow, time-shared pin set. An 8-bit port carries the low address byte first and the data byte afterwards. A separate 8-bit output carries the high address byte. An external transparent latch, clocked by an address-latch-enable strobe, holds the low address byte while the shared lines are reused for data.

The core raises a request with a 16-bit address, a direction bit and write data. It then holds that request until the bridge raises `ready` for one cycle. The bridge runs one access at a time in fixed phases:

- **Address phase:** the low byte is driven with the latch enable high.
- **Hold phase:** the low byte is still driven after the latch enable falls.
- **Setup phase:** for a write, the data is driven. For a read, the lines are released.
- **Strobe phase:** an active-low write or read strobe is held for a parameterised number of cycles.
- **Recovery phase:** write data stays driven after the strobe rises. For a read, the returned byte was captured on the clock edge that ended the read strobe.

Top module: `xmem_mux_bridge`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, `ale` is 0, `wr_n` and `rd_n` are 1, `ad_oe` is 0, `ready` is 0 and `rdata` is 0.
- R2: Each access places address bits [7:0] on `ad_out` with `ad_oe` high while `ale` is high. The same byte stays driven in the cycle after `ale` falls.
- R3: Throughout the strobe of every access, `a_hi` equals address bits [15:8] of that access.
- R4: In a write, `wdata` is on `ad_out` with `ad_oe` high one cycle before `wr_n` falls, during every cycle `wr_n` is 0, and in the cycle after `wr_n` rises.
- R5: In a read, `rdata` takes the `ad_in` value present in the last cycle that `rd_n` is 0. It then keeps that value until the next read completes.
- R6: With `STB_CYC` strobe cycles, `ready` goes high `STB_CYC+4` clock edges after the edge that first sees `req` high in idle. `ready` stays high for exactly one cycle.
- R7: `ad_oe` is 0 in the setup cycle before a read strobe and in every cycle `rd_n` is 0.
- R8: `wr_n` and `rd_n` are never 0 together, and neither is 0 while `ale` is 1.
- R9: `addr`, `we` and `wdata` are sampled only on the edge that accepts the request. Changes during the access have no effect on that access's pins or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read result |
| ad_out | output | 8 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared address/data lines, incoming value |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The bench uses a latch-plus-memory model. The first pattern is a read sweep over all 256 low-address values with a fixed high byte against unwritten memory, whose contents come from an address formula. This sweep separates correct low-address latching from the high byte. A write sweep with a different high byte for every location, followed by a read-back sweep, shows whether write data, strobe timing and high-address drive agree. A second read sweep on the same low bytes with different high bytes must miss every written location, which proves the high byte reaches the memory. A final group of accesses changes `addr`, `we` and `wdata` just after acceptance, so that sampled and live inputs can be told apart.

// File: rtl/xmem_pkg.sv
// Shared types for the multiplexed external memory bridge.
// Assumes: phase order is fixed; each module decodes the phase it needs.
package xmem_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_HOLD    = 3'd2,
        PH_SETUP   = 3'd3,
        PH_STROBE  = 3'd4,
        PH_RECOVER = 3'd5
    } phase_t;
endpackage

// File: rtl/xmem_seq.sv
// Phase sequencer: accepts one request from idle, latches its fields and
// walks the address, hold, setup, strobe and recovery phases.
// Assumes: the core holds req until ready; STB_CYC >= 1.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output phase_t            phase,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_we,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              cap_en
);
    localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
    localparam logic [CW-1:0] STB_LAST = CW'(STB_CYC - 1);

    logic [CW-1:0] stb_cnt;
    logic          stb_done;

    // Last strobe cycle reached.
    assign stb_done = (stb_cnt == STB_LAST);
    // Capture read data on the edge that ends the read strobe.
    assign cap_en = (phase == PH_STROBE) && stb_done && !lat_we;

    // Advance the phase and count strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            stb_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE:    if (req) phase <= PH_ADDR;
                PH_ADDR:    phase <= PH_HOLD;
                PH_HOLD:    phase <= PH_SETUP;
                PH_SETUP: begin
                    phase   <= PH_STROBE;
                    stb_cnt <= '0;
                end
                PH_STROBE: begin
                    if (stb_done) phase <= PH_RECOVER;
                    else          stb_cnt <= stb_cnt + 1'b1;
                end
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    // Sample the request fields only when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
        end else if (phase == PH_IDLE && req) begin
            lat_addr  <= addr;
            lat_we    <= we;
            lat_wdata <= wdata;
        end
    end
endmodule

// File: rtl/xmem_pads.sv
// Pin decoder: turns the phase and the latched request into latch enable,
// strobes, shared-line drive value and drive enable.
// Assumes: DATA_W is the low address slice width as well as the data width.
module xmem_pads
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic              lat_we,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              ale,
    output logic              wr_n,
    output logic              rd_n,
    output logic              ready
);
    // The high address byte follows the latched address throughout.
    assign a_hi = lat_addr[ADDR_W-1:DATA_W];

    // Decode the per-phase pin values.
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        ale    = 1'b0;
        wr_n   = 1'b1;
        rd_n   = 1'b1;
        ready  = 1'b0;
        case (phase)
            PH_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = lat_addr[DATA_W-1:0];
            end
            PH_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = lat_addr[DATA_W-1:0];
            end
            PH_SETUP: begin
                ad_oe  = lat_we;
                ad_out = lat_we ? lat_wdata : '0;
            end
            PH_STROBE: begin
                ad_oe  = lat_we;
                ad_out = lat_we ? lat_wdata : '0;
                wr_n   = !lat_we;
                rd_n   = lat_we;
            end
            PH_RECOVER: begin
                ad_oe  = lat_we;
                ad_out = lat_we ? lat_wdata : '0;
                ready  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xmem_rcap.sv
// Read capture register: stores the shared-line value when enabled.
// Assumes: the enable is high for exactly the last read-strobe cycle.
module xmem_rcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);
    // Hold the last read result until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= ad_in;
    end
endmodule

// File: rtl/xmem_mux_bridge.sv
// Top of the multiplexed external memory bridge: sequencer, pin decoder
// and read capture. Assumes one outstanding access and an external latch
// that is transparent while ale is high.
module xmem_mux_bridge
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int STB_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     ready,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     wr_n,
    output logic                     rd_n
);
    phase_t            phase;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;
    logic              cap_en;

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_CYC(STB_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .phase(phase), .lat_addr(lat_addr),
        .lat_we(lat_we), .lat_wdata(lat_wdata), .cap_en(cap_en)
    );

    xmem_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .phase(phase), .lat_addr(lat_addr), .lat_we(lat_we),
        .lat_wdata(lat_wdata), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .ready(ready)
    );

    xmem_rcap #(.DATA_W(DATA_W)) u_rcap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .ad_in(ad_in),
        .rdata(rdata)
    );
endmodule

// File: rtl/xmem_mux_bridge_chk.sv
// Protocol checker for the bridge pins; bound to every bridge instance.
module xmem_mux_bridge_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              wr_n,
    input logic              rd_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic              ready
);
    // R2
    ale_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ad_oe && $stable(ad_out));
    // R4
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(ad_oe) && $stable(ad_out));
    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe && $stable(ad_out));
    // R7
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));
    // R8
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> wr_n && rd_n);
    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
endmodule

bind xmem_mux_bridge xmem_mux_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .ready(ready)
);

// File: tb/xmem_mux_bridge_test.sv
`timescale 1ns/1ps
module xmem_mux_bridge_test;
    localparam int STB = 2;
    localparam int LAT = STB + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic [7:0]  a_hi;
    logic        ale;
    logic        wr_n;
    logic        rd_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xmem_mux_bridge #(.ADDR_W(16), .DATA_W(8), .STB_CYC(STB)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ready(ready), .rdata(rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
        .wr_n(wr_n), .rd_n(rd_n)
    );

    // External latch and memory model.
    logic [7:0] m_lat = '0;
    logic [7:0] m_hi = '0;
    logic [7:0] mem [256];
    logic [7:0] tag [256];
    logic       vld [256];
    logic [7:0] last_rd_in = '0;

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb begin
        if (!rd_n)
            ad_in = (vld[m_lat] && tag[m_lat] == a_hi) ? mem[m_lat]
                                                       : fill({a_hi, m_lat});
        else
            ad_in = 8'h00;
    end

    task automatic chk(input bit ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Sample the pins between edges.
    always @(negedge clk) begin
        if (ale) m_lat <= ad_out;
        if (!wr_n) begin
            mem[m_lat] <= ad_out;
            tag[m_lat] <= a_hi;
            vld[m_lat] <= 1'b1;
            m_hi <= a_hi;
        end
        if (!rd_n) begin
            m_hi <= a_hi;
            last_rd_in <= ad_in;
            chk(!ad_oe, "R7 drive during read strobe", ad_oe, 0);
            chk(wr_n, "R8 both strobes low", wr_n, 1);
        end
        if (ale) chk(wr_n && rd_n, "R8 strobe with ale", {wr_n, rd_n}, 3);
    end

    task automatic access(input bit w, input logic [15:0] a,
                          input logic [7:0] d, input bit corrupt,
                          output logic [7:0] rd);
        int n;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && corrupt) begin
                we = !w; addr = ~a; wdata = ~d;
            end
        end while (!ready && n < 50);
        chk(n == LAT, "R6 latency", n, LAT);
        rd = rdata;
        req = 1'b0;
        @(negedge clk);
        chk(!ready, "R6 single ready", ready, 0);
        chk(m_lat == a[7:0], "R2 latched low address", m_lat, a[7:0]);
        chk(m_hi == a[15:8], "R3 high address", m_hi, a[15:8]);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 256; i++) vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state, during and just after reset
        chk({ale, wr_n, rd_n, ad_oe, ready} == 5'b01100, "R1 pins in reset",
            {ale, wr_n, rd_n, ad_oe, ready}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ale, wr_n, rd_n, ad_oe, ready} == 5'b01100, "R1 pins after reset",
            {ale, wr_n, rd_n, ad_oe, ready}, 5'b01100);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);

        // Read sweep over unwritten memory (R5)
        for (int i = 0; i < 256; i++) begin
            access(1'b0, {8'hA5, 8'(i)}, 8'h00, 1'b0, r);
            chk(r == fill({8'hA5, 8'(i)}), "R5 read fill", r,
                fill({8'hA5, 8'(i)}));
        end
        // Write sweep with a distinct high byte per location (R4)
        for (int i = 0; i < 256; i++) begin
            access(1'b1, {8'(i * 3 + 1), 8'(i)}, 8'(i) ^ 8'hC3, 1'b0, r);
            chk(mem[i] == (8'(i) ^ 8'hC3), "R4 write data", mem[i],
                8'(i) ^ 8'hC3);
            chk(r == last_rd_in, "R5 rdata held over write", r, last_rd_in);
        end
        // Read-back sweep (R5)
        for (int i = 0; i < 256; i++) begin
            access(1'b0, {8'(i * 3 + 1), 8'(i)}, 8'h00, 1'b0, r);
            chk(r == (8'(i) ^ 8'hC3), "R5 read back", r, 8'(i) ^ 8'hC3);
        end
        // High byte mismatch must miss (R3)
        for (int i = 0; i < 256; i++) begin
            access(1'b0, {8'(i * 3 + 2), 8'(i)}, 8'h00, 1'b0, r);
            chk(r == fill({8'(i * 3 + 2), 8'(i)}), "R3 other page", r,
                fill({8'(i * 3 + 2), 8'(i)}));
        end
        // Inputs changed after acceptance are ignored (R9)
        for (int i = 0; i < 16; i++) begin
            access(1'b1, {8'h3C, 8'(i * 16)}, 8'(i) ^ 8'h96, 1'b1, r);
            chk(mem[i * 16] == (8'(i) ^ 8'h96) && tag[i * 16] == 8'h3C,
                "R9 write kept fields", mem[i * 16], 8'(i) ^ 8'h96);
            access(1'b0, {8'h3C, 8'(i * 16)}, 8'h00, 1'b1, r);
            chk(r == (8'(i) ^ 8'h96), "R9 read kept fields", r,
                8'(i) ^ 8'h96);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule